// File: doc/BRIEF.md
# Loop Counter and Condition Flag Unit

This unit keeps the iteration counter and the condition flags of one programmable network endpoint. A sequencer outside the unit decodes each operation and sends strobes: load the counter, step it down, report a torpedo strike, rewrite the general flags, or refresh the control flag. The unit applies all the changes that one operation requests on a single clock edge. It also gives back a predicate answer for the instruction that is about to run.

The two general flags are rewritten by a pair of 6-bit select masks. Each mask ORs together any chosen mix of the old flag values and their complements. The control flag is refreshed from the routing signal bit of the packet, or, at an output endpoint, from a value the attached unit provides. The predicate flag clears itself when a torpedo strikes or when a count-down reaches zero. The zero flag follows the counter with no delay. A build parameter selects the input-endpoint or output-endpoint form.

Top module: `loop_flag_unit`

## Requirements
- R1: During and after an active-low reset, `count_o` is 0, flags A, B, C and P are 0, and Z is 1.
- R2: When `cnt_load_i` is high, `count_o` equals `cnt_load_val_i` after the next clock edge. A load takes priority over a decrement in the same cycle.
- R3: When `cnt_dec_i` is high without a load, a nonzero counter decreases by one. A counter already at 0 stays at 0.
- R4: `flag_z_o` is high exactly when `count_o` is 0, in the same cycle, with no register in between.
- R5: P is cleared on the edge where `torpedo_i` is high, and on the edge where a decrement takes the counter from 1 to 0. A decrement at 0 does not clear P, and neither does a load of 0.
- R6: When `flag_set_i` is high, new A = OR over the set bits of `next_a_sel_i` of the terms bit5=A, bit4=~A, bit3=B, bit2=~B, bit1=C, bit0=~C. New B is formed from `next_b_sel_i` in the same way. An all-zero mask gives 0.
- R7: All terms use the flag values held before the edge, and every update commits together. Masks A=0b100000 and B=0b001000 leave the flags unchanged. Masks A=0b001000 and B=0b100000 swap A and B. A mask that selects a flag together with its complement gives 1.
- R8: In the output-endpoint form (`OUT_DOCK`=1), a high `c_upd_i` loads C from `ship_val_i` when `capture_i` is 1, and from `sig_bit_i` when `capture_i` is 0.
- R9: In the input-endpoint form (`OUT_DOCK`=0), a high `c_upd_i` loads C from `sig_bit_i`, and `capture_i` has no effect.
- R10: `pred_ok_o` = `pred_u_i` OR P, combinationally.
- R11: When `flag_set_i` and `p_wr_i` are both high, P takes `p_val_i`. A clearing event in the same cycle (see R5) wins and P becomes 0.
- R12: When no strobe is high, A, B, C, P and the counter keep their values, whatever the data inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_load_i | input | 1 | Counter load strobe |
| cnt_load_val_i | input | CNT_W (37) | Value to load into the counter |
| cnt_dec_i | input | 1 | Counter decrement strobe |
| torpedo_i | input | 1 | Torpedo strike strobe |
| flag_set_i | input | 1 | Set-flags command strobe |
| next_a_sel_i | input | 6 | Select mask for the new A |
| next_b_sel_i | input | 6 | Select mask for the new B |
| p_wr_i | input | 1 | The set-flags command also writes P |
| p_val_i | input | 1 | Value written to P |
| c_upd_i | input | 1 | Control flag update strobe |
| sig_bit_i | input | 1 | Signal bit of the packet |
| ship_val_i | input | 1 | Value provided by the attached unit |
| capture_i | input | 1 | Data-capture select |
| pred_u_i | input | 1 | Unconditional bit of the pending instruction |
| pred_ok_o | output | 1 | The pending instruction may execute |
| flag_a_o | output | 1 | Flag A |
| flag_b_o | output | 1 | Flag B |
| flag_c_o | output | 1 | Control flag C |
| flag_p_o | output | 1 | Predicate flag P |
| flag_z_o | output | 1 | Zero flag |
| count_o | output | CNT_W (37) | Loop counter value |

## Verification
The assertions check these rules on every cycle:
- the counter steps by one, stops at zero, and a load wins over a decrement;
- Z and the predicate output agree with the counter and P;
- a torpedo clears P;
- the output-endpoint capture path loads C from the right source;
- flags and counter hold when no strobe is high.

The OR-select logic is covered only by the bench. It sweeps every mask value against all eight starting flag states for both A and B. The bench scenarios also show the ordering rules:
- two flags are swapped correctly;
- a clearing event wins over a P write;
- a decrement to zero clears P, while a load of zero does not;
- the input endpoint ignores the capture select.

// File: rtl/lfu_pkg.sv
`timescale 1ns/1ps
package lfu_pkg;
  localparam int FSEL_W = 6;
  // mask bit positions
  localparam int SEL_A  = 5;
  localparam int SEL_NA = 4;
  localparam int SEL_B  = 3;
  localparam int SEL_NB = 2;
  localparam int SEL_C  = 1;
  localparam int SEL_NC = 0;
  localparam int NUM_GP = 2; // general flags A and B

  typedef struct packed {
    logic a;
    logic b;
    logic c;
  } flag_src_t;
endpackage

// File: rtl/lfu_counter.sv
`timescale 1ns/1ps
module lfu_counter #(
  parameter int CNT_W = 37
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] count_o,
  output logic             zero_o,
  output logic             hit_zero_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             is_zero;

  assign is_zero = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (dec_i && !is_zero) begin
      cnt_q <= cnt_q - ONE;
    end
  end

  assign count_o    = cnt_q;
  assign zero_o     = is_zero;
  // step from one to zero on this edge
  assign hit_zero_o = dec_i && !load_i && (cnt_q == ONE);
endmodule

// File: rtl/lfu_flag_sel.sv
`timescale 1ns/1ps
module lfu_flag_sel
  import lfu_pkg::*;
(
  input  flag_src_t         old_i,
  input  logic [FSEL_W-1:0] sel_i,
  output logic              new_o
);
  logic [FSEL_W-1:0] terms;

  always_comb begin
    terms         = '0;
    terms[SEL_A]  = old_i.a;
    terms[SEL_NA] = ~old_i.a;
    terms[SEL_B]  = old_i.b;
    terms[SEL_NB] = ~old_i.b;
    terms[SEL_C]  = old_i.c;
    terms[SEL_NC] = ~old_i.c;
  end

  assign new_o = |(terms & sel_i);
endmodule

// File: rtl/lfu_c_src.sv
`timescale 1ns/1ps
module lfu_c_src #(
  parameter bit OUT_DOCK = 1'b1
) (
  input  logic sig_bit_i,
  input  logic ship_val_i,
  input  logic capture_i,
  output logic c_new_o
);
  if (OUT_DOCK) begin : g_out
    assign c_new_o = capture_i ? ship_val_i : sig_bit_i;
  end else begin : g_in
    logic unused_cap;
    assign unused_cap = ship_val_i ^ capture_i;
    assign c_new_o    = sig_bit_i;
  end
endmodule

// File: rtl/loop_flag_unit.sv
`timescale 1ns/1ps
module loop_flag_unit
  import lfu_pkg::*;
#(
  parameter int CNT_W    = 37,
  parameter bit OUT_DOCK = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cnt_load_i,
  input  logic [CNT_W-1:0]  cnt_load_val_i,
  input  logic              cnt_dec_i,
  input  logic              torpedo_i,
  input  logic              flag_set_i,
  input  logic [FSEL_W-1:0] next_a_sel_i,
  input  logic [FSEL_W-1:0] next_b_sel_i,
  input  logic              p_wr_i,
  input  logic              p_val_i,
  input  logic              c_upd_i,
  input  logic              sig_bit_i,
  input  logic              ship_val_i,
  input  logic              capture_i,
  input  logic              pred_u_i,
  output logic              pred_ok_o,
  output logic              flag_a_o,
  output logic              flag_b_o,
  output logic              flag_c_o,
  output logic              flag_p_o,
  output logic              flag_z_o,
  output logic [CNT_W-1:0]  count_o
);
  logic                           hit_zero;
  logic                           c_new;
  logic [NUM_GP-1:0]              gp_q;
  logic [NUM_GP-1:0]              gp_next;
  logic [NUM_GP-1:0][FSEL_W-1:0]  sel_arr;
  logic                           c_q;
  logic                           p_q;
  logic                           p_clr;
  flag_src_t                      old_flags;

  lfu_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (cnt_load_i),
    .load_val_i (cnt_load_val_i),
    .dec_i      (cnt_dec_i),
    .count_o    (count_o),
    .zero_o     (flag_z_o),
    .hit_zero_o (hit_zero)
  );

  assign old_flags = '{a: gp_q[0], b: gp_q[1], c: c_q};
  assign sel_arr   = {next_b_sel_i, next_a_sel_i};

  for (genvar i = 0; i < NUM_GP; i++) begin : g_sel
    lfu_flag_sel u_sel (
      .old_i (old_flags),
      .sel_i (sel_arr[i]),
      .new_o (gp_next[i])
    );
  end

  lfu_c_src #(.OUT_DOCK(OUT_DOCK)) u_csrc (
    .sig_bit_i  (sig_bit_i),
    .ship_val_i (ship_val_i),
    .capture_i  (capture_i),
    .c_new_o    (c_new)
  );

  assign p_clr = torpedo_i | hit_zero;

  // all flags commit on one edge from pre-edge values
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gp_q <= '0;
      c_q  <= 1'b0;
      p_q  <= 1'b0;
    end else begin
      if (flag_set_i) gp_q <= gp_next;
      if (c_upd_i)    c_q  <= c_new;
      if (p_clr)                      p_q <= 1'b0;
      else if (flag_set_i && p_wr_i)  p_q <= p_val_i;
    end
  end

  assign flag_a_o  = gp_q[0];
  assign flag_b_o  = gp_q[1];
  assign flag_c_o  = c_q;
  assign flag_p_o  = p_q;
  assign pred_ok_o = pred_u_i | p_q;
endmodule

// File: rtl/lfu_checker.sv
`timescale 1ns/1ps
module lfu_checker #(
  parameter int CNT_W    = 37,
  parameter bit OUT_DOCK = 1'b1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cnt_load_i,
  input logic [CNT_W-1:0] cnt_load_val_i,
  input logic             cnt_dec_i,
  input logic             torpedo_i,
  input logic             flag_set_i,
  input logic             p_wr_i,
  input logic             c_upd_i,
  input logic             sig_bit_i,
  input logic             ship_val_i,
  input logic             capture_i,
  input logic             pred_u_i,
  input logic             pred_ok_o,
  input logic             flag_a_o,
  input logic             flag_b_o,
  input logic             flag_c_o,
  input logic             flag_p_o,
  input logic             flag_z_o,
  input logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  AST_LOAD_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_load_i |=> count_o == $past(cnt_load_val_i)); // R2

  AST_DEC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_dec_i && !cnt_load_i && count_o != '0) |=> count_o == $past(count_o) - ONE); // R3

  AST_DEC_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_dec_i && !cnt_load_i && count_o == '0) |=> count_o == '0); // R3

  AST_ZERO_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_z_o == (count_o == '0)); // R4

  AST_TORPEDO_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    torpedo_i |=> !flag_p_o); // R5

  AST_REACH_ZERO_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_dec_i && !cnt_load_i && count_o == ONE) |=> !flag_p_o); // R5

  AST_CAPTURE_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (OUT_DOCK && c_upd_i && capture_i) |=> flag_c_o == $past(ship_val_i)); // R8

  AST_SIG_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_upd_i && (!OUT_DOCK || !capture_i)) |=> flag_c_o == $past(sig_bit_i)); // R9

  AST_PRED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pred_ok_o == (pred_u_i | flag_p_o)); // R10

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_set_i && !c_upd_i) |=> $stable({flag_a_o, flag_b_o, flag_c_o})); // R12

  AST_P_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!torpedo_i && !cnt_dec_i && !(flag_set_i && p_wr_i)) |=> $stable(flag_p_o)); // R12

  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnt_load_i && !cnt_dec_i) |=> $stable(count_o)); // R12
endmodule

bind loop_flag_unit lfu_checker #(.CNT_W(CNT_W), .OUT_DOCK(OUT_DOCK)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .cnt_load_i     (cnt_load_i),
  .cnt_load_val_i (cnt_load_val_i),
  .cnt_dec_i      (cnt_dec_i),
  .torpedo_i      (torpedo_i),
  .flag_set_i     (flag_set_i),
  .p_wr_i         (p_wr_i),
  .c_upd_i        (c_upd_i),
  .sig_bit_i      (sig_bit_i),
  .ship_val_i     (ship_val_i),
  .capture_i      (capture_i),
  .pred_u_i       (pred_u_i),
  .pred_ok_o      (pred_ok_o),
  .flag_a_o       (flag_a_o),
  .flag_b_o       (flag_b_o),
  .flag_c_o       (flag_c_o),
  .flag_p_o       (flag_p_o),
  .flag_z_o       (flag_z_o),
  .count_o        (count_o)
);

// File: tb/loop_flag_unit_tb.sv
`timescale 1ns/1ps
module loop_flag_unit_tb;
  localparam int CNT_W = 37;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             cnt_load_i = 1'b0;
  logic [CNT_W-1:0] cnt_load_val_i = '0;
  logic             cnt_dec_i = 1'b0;
  logic             torpedo_i = 1'b0;
  logic             flag_set_i = 1'b0;
  logic [5:0]       next_a_sel_i = '0;
  logic [5:0]       next_b_sel_i = '0;
  logic             p_wr_i = 1'b0;
  logic             p_val_i = 1'b0;
  logic             c_upd_i = 1'b0;
  logic             sig_bit_i = 1'b0;
  logic             ship_val_i = 1'b0;
  logic             capture_i = 1'b0;
  logic             pred_u_i = 1'b0;

  logic             pred_ok_o, flag_a_o, flag_b_o, flag_c_o, flag_p_o, flag_z_o;
  logic [CNT_W-1:0] count_o;
  logic             in_pred, in_a, in_b, in_c, in_p, in_z;
  logic [CNT_W-1:0] in_count;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  loop_flag_unit #(.CNT_W(CNT_W), .OUT_DOCK(1'b1)) u_dut (
    .clk_i, .rst_ni, .cnt_load_i, .cnt_load_val_i, .cnt_dec_i, .torpedo_i,
    .flag_set_i, .next_a_sel_i, .next_b_sel_i, .p_wr_i, .p_val_i, .c_upd_i,
    .sig_bit_i, .ship_val_i, .capture_i, .pred_u_i, .pred_ok_o, .flag_a_o,
    .flag_b_o, .flag_c_o, .flag_p_o, .flag_z_o, .count_o
  );

  loop_flag_unit #(.CNT_W(CNT_W), .OUT_DOCK(1'b0)) u_dut_in (
    .clk_i, .rst_ni, .cnt_load_i, .cnt_load_val_i, .cnt_dec_i, .torpedo_i,
    .flag_set_i, .next_a_sel_i, .next_b_sel_i, .p_wr_i, .p_val_i, .c_upd_i,
    .sig_bit_i, .ship_val_i, .capture_i, .pred_u_i,
    .pred_ok_o(in_pred), .flag_a_o(in_a), .flag_b_o(in_b), .flag_c_o(in_c),
    .flag_p_o(in_p), .flag_z_o(in_z), .count_o(in_count)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk_i);
  endtask

  function automatic logic sel_eval(input logic [5:0] m, input logic a, input logic b, input logic c);
    return (m[5] & a) | (m[4] & ~a) | (m[3] & b) | (m[2] & ~b) | (m[1] & c) | (m[0] & ~c);
  endfunction

  task automatic set_flags(input logic [5:0] ma, input logic [5:0] mb);
    flag_set_i = 1'b1; next_a_sel_i = ma; next_b_sel_i = mb;
    tick();
    flag_set_i = 1'b0;
  endtask

  task automatic set_c(input logic v);
    c_upd_i = 1'b1; capture_i = 1'b0; sig_bit_i = v;
    tick();
    c_upd_i = 1'b0;
  endtask

  task automatic set_p(input logic v);
    flag_set_i = 1'b1; next_a_sel_i = 6'b100000; next_b_sel_i = 6'b001000;
    p_wr_i = 1'b1; p_val_i = v;
    tick();
    flag_set_i = 1'b0; p_wr_i = 1'b0;
  endtask

  task automatic load(input logic [CNT_W-1:0] v);
    cnt_load_i = 1'b1; cnt_load_val_i = v;
    tick();
    cnt_load_i = 1'b0;
  endtask

  task automatic dec();
    cnt_dec_i = 1'b1;
    tick();
    cnt_dec_i = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #12;
    // R1 values while reset is held
    chk("R1 count", 64'(count_o), 0);
    chk("R1 flags abcp", {60'd0, flag_a_o, flag_b_o, flag_c_o, flag_p_o}, 0);
    chk("R1 z", 64'(flag_z_o), 1);
    @(negedge clk_i);
    rst_ni = 1'b1;
    tick();
    chk("R1 after release", {58'd0, flag_a_o, flag_b_o, flag_c_o, flag_p_o, flag_z_o, in_z}, 6'b000011);

    // R6 exhaustive: every mask against every old A/B/C state, for A and for B
    for (int s = 0; s < 8; s++) begin
      for (int m = 0; m < 64; m++) begin
        logic oa, ob, oc, ea, eb;
        oa = s[2]; ob = s[1]; oc = s[0];
        set_flags(oa ? 6'b110000 : 6'b000000, ob ? 6'b001100 : 6'b000000);
        set_c(oc);
        set_flags(6'(m), 6'(63 - m));
        ea = sel_eval(6'(m), oa, ob, oc);
        eb = sel_eval(6'(63 - m), oa, ob, oc);
        chk("R6 new A", 64'(flag_a_o), 64'(ea));
        chk("R6 new B", 64'(flag_b_o), 64'(eb));
        chk("R6 C kept", 64'(flag_c_o), 64'(oc));
      end
    end

    // R7 no-op, swap, flag with complement
    set_flags(6'b110000, 6'b000000); // A=1 B=0
    set_flags(6'b100000, 6'b001000);
    chk("R7 no-op", {62'd0, flag_a_o, flag_b_o}, 2'b10);
    set_flags(6'b001000, 6'b100000);
    chk("R7 swap", {62'd0, flag_a_o, flag_b_o}, 2'b01);
    set_c(1'b0);
    set_flags(6'b000011, 6'b000000);
    chk("R7 c or not c", {62'd0, flag_a_o, flag_b_o}, 2'b10);

    // R8 output endpoint C sources, R9 input endpoint ignores capture
    for (int k = 0; k < 8; k++) begin
      c_upd_i = 1'b1; capture_i = k[2]; ship_val_i = k[1]; sig_bit_i = k[0];
      tick();
      c_upd_i = 1'b0;
      chk("R8 out C", 64'(flag_c_o), 64'(k[2] ? k[1] : k[0]));
      chk("R9 in C", 64'(in_c), 64'(k[0]));
    end

    // R12 idle: data inputs toggle, no strobes
    set_flags(6'b110000, 6'b000000);
    set_c(1'b1);
    set_p(1'b1);
    load(37'd5);
    for (int k = 0; k < 4; k++) begin
      sig_bit_i = k[0]; ship_val_i = k[1]; capture_i = 1'b1;
      next_a_sel_i = 6'(k * 13); next_b_sel_i = 6'(k * 7); p_val_i = k[0];
      cnt_load_val_i = 37'(k + 100);
      tick();
      chk("R12 hold", {59'd0, flag_a_o, flag_b_o, flag_c_o, flag_p_o, 1'b0}, 5'b10110);
      chk("R12 count hold", 64'(count_o), 5);
    end

    // R10 predicate
    for (int k = 0; k < 4; k++) begin
      set_p(k[1]);
      pred_u_i = k[0];
      #1;
      chk("R10 pred", 64'(pred_ok_o), 64'(k[0] | k[1]));
    end
    pred_u_i = 1'b0;

    // R2 load, including max, and priority over decrement
    load({CNT_W{1'b1}});
    chk("R2 load max", 64'(count_o), 64'({CNT_W{1'b1}}));
    dec();
    chk("R3 dec max", 64'(count_o), 64'({CNT_W{1'b1}}) - 1);
    cnt_load_i = 1'b1; cnt_dec_i = 1'b1; cnt_load_val_i = 37'd9;
    tick();
    cnt_load_i = 1'b0; cnt_dec_i = 1'b0;
    chk("R2 load over dec", 64'(count_o), 9);

    // R3 and R5: count down from 3, P cleared only on reaching zero
    load(37'd3);
    set_p(1'b1);
    for (int k = 2; k >= 0; k--) begin
      dec();
      chk("R3 step", 64'(count_o), 64'(k));
      chk("R4 z", 64'(flag_z_o), 64'(k == 0));
      chk("R5 p on reach zero", 64'(flag_p_o), 64'(k != 0));
    end
    set_p(1'b1);
    dec();
    chk("R3 floor", 64'(count_o), 0);
    chk("R5 dec at zero keeps p", 64'(flag_p_o), 1);
    load(37'd0);
    chk("R5 load zero keeps p", 64'(flag_p_o), 1);
    chk("R4 z after zero load", 64'(flag_z_o), 1);

    // R5 torpedo
    torpedo_i = 1'b1;
    tick();
    torpedo_i = 1'b0;
    chk("R5 torpedo", 64'(flag_p_o), 0);

    // R11 clear wins over P write
    flag_set_i = 1'b1; next_a_sel_i = 6'b100000; next_b_sel_i = 6'b001000;
    p_wr_i = 1'b1; p_val_i = 1'b1; torpedo_i = 1'b1;
    tick();
    flag_set_i = 1'b0; p_wr_i = 1'b0; torpedo_i = 1'b0;
    chk("R11 torpedo wins", 64'(flag_p_o), 0);
    load(37'd1);
    cnt_dec_i = 1'b1; flag_set_i = 1'b1; p_wr_i = 1'b1; p_val_i = 1'b1;
    tick();
    cnt_dec_i = 1'b0; flag_set_i = 1'b0; p_wr_i = 1'b0;
    chk("R11 reach zero wins", 64'(flag_p_o), 0);
    set_p(1'b1);
    chk("R11 p write", 64'(flag_p_o), 1);
    set_p(1'b0);
    chk("R11 p write 0", 64'(flag_p_o), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule